// File: doc/BRIEF.md
# Compressed instruction expander

This block turns one 16-bit compressed RISC-V instruction into the 32-bit base-ISA word that does the same work on an RV32 core. A decode stage places it behind the fetch aligner. Each cycle in which `in_valid` is high, the block takes the halfword on `in_half`. One clock later it presents the expanded word, a flag that marks the halfword as unusable, and a strobe that marks the result as fresh.

All three compressed quadrants are decoded. The block gathers the scattered immediate bits of each format back into order and applies sign or zero extension. It widens the 3-bit short register fields to x8..x15. It rejects reserved encodings, RV64-only forms, floating-point loads and stores, and any halfword that is not compressed. A rejected halfword always produces an all-zero word, so later stages can trap on one fixed pattern.

Top module: `rvc_expander`

## Requirements
- R1: A halfword with bits [1:0] = 11, the all-zero halfword, quadrant-0 funct3 001/011/100/101/111 and quadrant-2 funct3 001/011/101/111 all set `out_illegal` high.
- R2: Whenever `out_illegal` is high, `out_word` is 32'h0000_0000.
- R3: `out_valid` equals the previous cycle's `in_valid`. Synchronous reset forces `out_valid`, `out_word` and `out_illegal` to zero, and it wins over a concurrent `in_valid`. When `in_valid` is low, `out_word` and `out_illegal` keep their values.
- R4: A 3-bit short register field f always names register 8+f in the expanded word.
- R5: Quadrant 0, funct3 000 expands to ADDI rd', x2, u. Here u = c[10:7]*64 + c[12:11]*16 + c[5]*8 + c[6]*4, and u = 0 is illegal.
- R6: Quadrant 0, funct3 010 and 110 expand to LW rd', u(rs1') and SW rs2', u(rs1'), where u = c[12:10]*8 + c[6]*4 + c[5]*64.
- R7: Quadrant 1, funct3 001 and 101 expand to JAL x1 and JAL x0 respectively. The offset is the signed value of c12:c8:c[10:9]:c6:c7:c2:c11:c[5:3]:0.
- R8: Quadrant 1, funct3 000 and 010 give ADDI rd,rd,s and ADDI rd,x0,s with s = signed {c12,c[6:2]}. Funct3 011 with rd = 2 gives ADDI x2,x2,t, where t is signed c12:c[4:3]:c5:c2:c6 times 16, and t = 0 is illegal. Funct3 011 with any other rd gives LUI rd,{c12,c[6:2]} sign-extended, and rd = 0 or a zero value is illegal.
- R9: The shift forms in quadrant 1 (c[11:10] = 00 gives SRLI, 01 gives SRAI, both on rs1') and in quadrant 2 (funct3 000 gives SLLI on rd) take shamt = c[6:2]. They are illegal when c12 = 1 or shamt = 0. c[11:10] = 10 gives ANDI rs1',rs1',s.
- R10: Quadrant 1, funct3 100 with c[11:10] = 11 and c12 = 0 gives SUB, XOR, OR or AND for c[6:5] = 0..3, in the form rs1' = rs1' op rs2'. With c12 = 1 the halfword is illegal.
- R11: Quadrant 1, funct3 110 and 111 give BEQ and BNE rs1', x0. The offset is the signed value of c12:c[6:5]:c2:c[11:10]:c[4:3]:0.
- R12: Quadrant 2, funct3 100 decodes as follows:
  - c12 = 0, rs2 = 0: JALR x0, rd, 0. This is illegal when rd = 0.
  - c12 = 0, rs2 ≠ 0: ADD rd, x0, rs2.
  - c12 = 1, rd = 0, rs2 = 0: EBREAK.
  - c12 = 1, rd ≠ 0, rs2 = 0: JALR x1, rd, 0.
  - c12 = 1, rs2 ≠ 0: ADD rd, rd, rs2.
- R13: Quadrant 2, funct3 010 gives LW rd, u(x2) with u = c12*32 + c[6:4]*4 + c[3:2]*64, and rd = 0 is illegal. Funct3 110 gives SW rs2, v(x2) with v = c[12:9]*4 + c[8:7]*64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Halfword on `in_half` is to be expanded |
| in_half | input | 16 | Compressed instruction |
| out_valid | output | 1 | Result registered from a valid halfword |
| out_word | output | 32 | Expanded instruction, zero when illegal |
| out_illegal | output | 1 | Halfword is reserved, unsupported or not compressed |

## Verification
Two things can happen in the same cycle: a reset and the arrival of a valid halfword. The bench holds reset with `in_valid` high and a legal halfword on the input, then confirms that the output stays cleared. A second pair is the capture of a new word and the hold-over of the previous result. A legal halfword is followed by an idle cycle whose input carries a non-compressed pattern, and the bench checks that the earlier expansion is still on the output. Every one of the 65536 halfwords is then streamed back to back, and each result is compared with an arithmetic re-encoding computed in the bench.

// File: rtl/rvc_expander.sv
module rvc_expander (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [15:0] in_half,
  output logic        out_valid,
  output logic [31:0] out_word,
  output logic        out_illegal
);

  localparam logic [6:0] OP_IMM   = 7'h13;
  localparam logic [6:0] OP_REG   = 7'h33;
  localparam logic [6:0] OP_LOAD  = 7'h03;
  localparam logic [6:0] OP_STORE = 7'h23;
  localparam logic [6:0] OP_BR    = 7'h63;
  localparam logic [6:0] OP_JAL   = 7'h6f;
  localparam logic [6:0] OP_JALR  = 7'h67;
  localparam logic [6:0] OP_LUI   = 7'h37;
  localparam logic [31:0] WORD_EBREAK = 32'h0010_0073;

  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] enc_s(logic [11:0] off, logic [4:0] rs2, logic [4:0] rs1);
    return {off[11:5], rs2, rs1, 3'b010, off[4:0], OP_STORE};
  endfunction

  // j holds offset bits [20:1]
  function automatic logic [31:0] enc_j(logic [19:0] j, logic [4:0] rd);
    return {j[19], j[9:0], j[10], j[18:11], rd, OP_JAL};
  endfunction

  // b holds offset bits [12:1]
  function automatic logic [31:0] enc_b(logic [11:0] b, logic [4:0] rs1, logic [2:0] f3);
    return {b[11], b[9:4], 5'd0, rs1, f3, b[3:0], b[10], OP_BR};
  endfunction

  logic [15:0] c;
  assign c = in_half;

  logic [4:0] rd_full, rs2_full, lo_short, hi_short;
  assign rd_full  = c[11:7];
  assign rs2_full = c[6:2];
  assign lo_short = {2'b01, c[4:2]};
  assign hi_short = {2'b01, c[9:7]};

  logic [11:0] imm_spn, imm_word, imm_ci, imm_sp16, imm_lwsp, imm_swsp;
  logic [19:0] imm_lui, imm_jmp;
  logic [11:0] imm_br;
  logic [4:0]  shamt;

  assign imm_spn  = {2'b00, c[10:7], c[12:11], c[5], c[6], 2'b00};
  assign imm_word = {5'd0, c[5], c[12:10], c[6], 2'b00};
  assign imm_ci   = {{6{c[12]}}, c[12], c[6:2]};
  assign imm_sp16 = {{3{c[12]}}, c[4:3], c[5], c[2], c[6], 4'd0};
  assign imm_lui  = {{14{c[12]}}, c[12], c[6:2]};
  assign imm_jmp  = {{10{c[12]}}, c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3]};
  assign imm_br   = {{5{c[12]}}, c[6:5], c[2], c[11:10], c[4:3]};
  assign imm_lwsp = {4'd0, c[3:2], c[12], c[6:4], 2'b00};
  assign imm_swsp = {4'd0, c[8:7], c[12:9], 2'b00};
  assign shamt    = c[6:2];

  logic [31:0] nx;
  logic        bad;

  always_comb begin
    nx  = '0;
    bad = 1'b0;
    case (c[1:0])
      2'b00: begin
        case (c[15:13])
          3'b000: begin
            nx  = enc_i(imm_spn, 5'd2, 3'b000, lo_short, OP_IMM);
            bad = (imm_spn == 12'd0);
          end
          3'b010: nx = enc_i(imm_word, hi_short, 3'b010, lo_short, OP_LOAD);
          3'b110: nx = enc_s(imm_word, lo_short, hi_short);
          default: bad = 1'b1;
        endcase
      end
      2'b01: begin
        case (c[15:13])
          3'b000: nx = enc_i(imm_ci, rd_full, 3'b000, rd_full, OP_IMM);
          3'b001: nx = enc_j(imm_jmp, 5'd1);
          3'b010: nx = enc_i(imm_ci, 5'd0, 3'b000, rd_full, OP_IMM);
          3'b011: begin
            if (rd_full == 5'd2) begin
              nx  = enc_i(imm_sp16, 5'd2, 3'b000, 5'd2, OP_IMM);
              bad = (imm_sp16 == 12'd0);
            end else begin
              nx  = {imm_lui, rd_full, OP_LUI};
              bad = (rd_full == 5'd0) || ({c[12], c[6:2]} == 6'd0);
            end
          end
          3'b100: begin
            case (c[11:10])
              2'b00, 2'b01: begin
                nx  = enc_r({1'b0, c[10], 5'd0}, shamt, hi_short, 3'b101, hi_short, OP_IMM);
                bad = c[12] || (shamt == 5'd0);
              end
              2'b10: nx = enc_i(imm_ci, hi_short, 3'b111, hi_short, OP_IMM);
              default: begin
                bad = c[12];
                case (c[6:5])
                  2'b00:   nx = enc_r(7'h20, lo_short, hi_short, 3'b000, hi_short, OP_REG);
                  2'b01:   nx = enc_r(7'h00, lo_short, hi_short, 3'b100, hi_short, OP_REG);
                  2'b10:   nx = enc_r(7'h00, lo_short, hi_short, 3'b110, hi_short, OP_REG);
                  default: nx = enc_r(7'h00, lo_short, hi_short, 3'b111, hi_short, OP_REG);
                endcase
              end
            endcase
          end
          3'b101: nx = enc_j(imm_jmp, 5'd0);
          3'b110: nx = enc_b(imm_br, hi_short, 3'b000);
          default: nx = enc_b(imm_br, hi_short, 3'b001);
        endcase
      end
      2'b10: begin
        case (c[15:13])
          3'b000: begin
            nx  = enc_r(7'h00, shamt, rd_full, 3'b001, rd_full, OP_IMM);
            bad = c[12] || (shamt == 5'd0);
          end
          3'b010: begin
            nx  = enc_i(imm_lwsp, 5'd2, 3'b010, rd_full, OP_LOAD);
            bad = (rd_full == 5'd0);
          end
          3'b100: begin
            if (rs2_full != 5'd0)
              nx = enc_r(7'h00, rs2_full, c[12] ? rd_full : 5'd0, 3'b000, rd_full, OP_REG);
            else if (!c[12]) begin
              nx  = enc_i(12'd0, rd_full, 3'b000, 5'd0, OP_JALR);
              bad = (rd_full == 5'd0);
            end else if (rd_full == 5'd0)
              nx = WORD_EBREAK;
            else
              nx = enc_i(12'd0, rd_full, 3'b000, 5'd1, OP_JALR);
          end
          3'b110: nx = enc_s(imm_swsp, rs2_full, 5'd2);
          default: bad = 1'b1;
        endcase
      end
      default: bad = 1'b1;
    endcase
    if (c == 16'd0) bad = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word    <= bad ? 32'd0 : nx;
        out_illegal <= bad;
      end
    end
  end

  assert_not_compressed_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid && (in_half[1:0] == 2'b11 || in_half == 16'd0) |=> out_illegal);

  assert_zero_on_illegal_R2: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> out_word == 32'd0);

  assert_valid_latency_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_word) && $stable(out_illegal));

  assert_short_reg_map_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_half[1:0] == 2'b00 && in_half[15:13] == 3'b010
    |=> !out_illegal && out_word[11:7] == {2'b01, $past(in_half[4:2])});

  assert_reg_op_rv64_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_half[1:0] == 2'b01 && in_half[15:10] == 6'b100111 |=> out_illegal);

endmodule

// File: tb/tb_rvc_expander.sv
module tb_rvc_expander;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_half = 16'd0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rvc_expander dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_half(in_half),
    .out_valid(out_valid), .out_word(out_word), .out_illegal(out_illegal)
  );

  function automatic int fld(int c, int lsb, int width);
    return (c >> lsb) & ((1 << width) - 1);
  endfunction

  function automatic logic [31:0] mk_i(int imm, int rs1, int f3, int rd, int op);
    return 32'(((imm & 4095) << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op);
  endfunction

  function automatic logic [31:0] mk_r(int f7, int rs2, int rs1, int f3, int rd, int op);
    return 32'((f7 << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op);
  endfunction

  function automatic logic [31:0] mk_s(int off, int rs2, int rs1);
    int o = off & 4095;
    return 32'(((o >> 5) << 25) | (rs2 << 20) | (rs1 << 15) | (2 << 12) | ((o & 31) << 7) | 35);
  endfunction

  function automatic logic [31:0] mk_j(int off, int rd);
    int o = off & 32'h1f_ffff;
    return 32'((((o >> 20) & 1) << 31) | (((o >> 1) & 1023) << 21) | (((o >> 11) & 1) << 20)
               | (((o >> 12) & 255) << 12) | (rd << 7) | 111);
  endfunction

  function automatic logic [31:0] mk_b(int off, int rs1, int f3);
    int o = off & 8191;
    return 32'((((o >> 12) & 1) << 31) | (((o >> 5) & 63) << 25) | (rs1 << 15) | (f3 << 12)
               | (((o >> 1) & 15) << 8) | (((o >> 11) & 1) << 7) | 99);
  endfunction

  task automatic expect_of(input int c, output logic [31:0] w, output bit ill, output string tag);
    int q   = fld(c, 0, 2);
    int f3  = fld(c, 13, 3);
    int b12 = fld(c, 12, 1);
    int rd  = fld(c, 7, 5);
    int rs2 = fld(c, 2, 5);
    int sl  = 8 + fld(c, 2, 3);
    int sh  = 8 + fld(c, 7, 3);
    int s6  = fld(c, 2, 5) - 32 * b12;
    int v;
    w = 32'd0; ill = 1'b0; tag = "R1";
    if (q == 3 || c == 0) begin ill = 1'b1; return; end
    if (q == 0) begin
      case (f3)
        0: begin
          tag = "R5";
          v = fld(c, 7, 4) * 64 + fld(c, 11, 2) * 16 + fld(c, 5, 1) * 8 + fld(c, 6, 1) * 4;
          if (v == 0) ill = 1'b1; else w = mk_i(v, 2, 0, sl, 19);
        end
        2, 6: begin
          tag = "R6";
          v = fld(c, 10, 3) * 8 + fld(c, 6, 1) * 4 + fld(c, 5, 1) * 64;
          w = (f3 == 2) ? mk_i(v, sh, 2, sl, 3) : mk_s(v, sl, sh);
        end
        default: ill = 1'b1;
      endcase
    end else if (q == 1) begin
      case (f3)
        0: begin tag = "R8"; w = mk_i(s6, rd, 0, rd, 19); end
        2: begin tag = "R8"; w = mk_i(s6, 0, 0, rd, 19); end
        1, 5: begin
          tag = "R7";
          v = fld(c, 3, 3) * 2 + fld(c, 11, 1) * 16 + fld(c, 2, 1) * 32 + fld(c, 7, 1) * 64
            + fld(c, 6, 1) * 128 + fld(c, 9, 2) * 256 + fld(c, 8, 1) * 1024 - b12 * 2048;
          w = mk_j(v, (f3 == 1) ? 1 : 0);
        end
        3: begin
          tag = "R8";
          if (rd == 2) begin
            v = fld(c, 6, 1) * 16 + fld(c, 2, 1) * 32 + fld(c, 5, 1) * 64 + fld(c, 3, 2) * 128 - b12 * 512;
            if (v == 0) ill = 1'b1; else w = mk_i(v, 2, 0, 2, 19);
          end else begin
            if (rd == 0 || s6 == 0) ill = 1'b1;
            else w = 32'(((s6 & 32'hf_ffff) << 12) | (rd << 7) | 55);
          end
        end
        4: begin
          case (fld(c, 10, 2))
            0, 1: begin
              tag = "R9";
              if (b12 == 1 || rs2 == 0) ill = 1'b1;
              else w = mk_r(fld(c, 10, 1) * 32, rs2, sh, 5, sh, 19);
            end
            2: begin tag = "R9"; w = mk_i(s6, sh, 7, sh, 19); end
            default: begin
              tag = "R10";
              if (b12 == 1) ill = 1'b1;
              else case (fld(c, 5, 2))
                0: w = mk_r(32, sl, sh, 0, sh, 51);
                1: w = mk_r(0, sl, sh, 4, sh, 51);
                2: w = mk_r(0, sl, sh, 6, sh, 51);
                default: w = mk_r(0, sl, sh, 7, sh, 51);
              endcase
            end
          endcase
        end
        default: begin
          tag = "R11";
          v = fld(c, 3, 2) * 2 + fld(c, 10, 2) * 8 + fld(c, 2, 1) * 32 + fld(c, 5, 2) * 64 - b12 * 256;
          w = mk_b(v, sh, (f3 == 6) ? 0 : 1);
        end
      endcase
    end else begin
      case (f3)
        0: begin
          tag = "R9";
          if (b12 == 1 || rs2 == 0) ill = 1'b1; else w = mk_r(0, rs2, rd, 1, rd, 19);
        end
        2: begin
          tag = "R13";
          v = b12 * 32 + fld(c, 4, 3) * 4 + fld(c, 2, 2) * 64;
          if (rd == 0) ill = 1'b1; else w = mk_i(v, 2, 2, rd, 3);
        end
        4: begin
          tag = "R12";
          if (rs2 != 0) w = mk_r(0, rs2, b12 ? rd : 0, 0, rd, 51);
          else if (b12 == 0) begin
            if (rd == 0) ill = 1'b1; else w = mk_i(0, rd, 0, 0, 103);
          end else if (rd == 0) w = 32'h0010_0073;
          else w = mk_i(0, rd, 0, 1, 103);
        end
        6: begin
          tag = "R13";
          w = mk_s(fld(c, 9, 4) * 4 + fld(c, 7, 2) * 64, rs2, 2);
        end
        default: ill = 1'b1;
      endcase
    end
  endtask

  task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic check_word(input int c, input logic [31:0] w, input bit ill, input string tag);
    check(tag, out_valid == 1'b1, {31'd0, out_valid}, 32'd1);
    check(ill ? "R2" : tag, out_word == w, out_word, w);
    check(ill ? "R1" : tag, out_illegal == ill, {31'd0, out_illegal}, {31'd0, ill});
    if (c[1:0] == 2'b00 && c[15:13] == 3'b010)
      check("R4", out_word[11:7] == 5'(8 + c[4:2]), {27'd0, out_word[11:7]}, 32'(8 + c[4:2]));
  endtask

  initial begin
    logic [31:0] pw, lw_;
    bit          pill, lill;
    string       ptag, ltag;
    int          prev;

    in_valid = 1'b1;
    in_half  = 16'h4505;
    repeat (3) @(negedge clk);
    check("R3", out_valid == 1'b0, {31'd0, out_valid}, 32'd0);
    check("R3", out_word == 32'd0, out_word, 32'd0);
    check("R3", out_illegal == 1'b0, {31'd0, out_illegal}, 32'd0);

    rst = 1'b0;
    prev = -1;
    for (int c = 0; c < 65536; c++) begin
      @(negedge clk);
      if (prev >= 0) check_word(prev, pw, pill, ptag);
      in_half = 16'(c);
      expect_of(c, pw, pill, ptag);
      prev = c;
    end
    @(negedge clk);
    check_word(prev, pw, pill, ptag);

    in_half = 16'h4505;
    expect_of(32'h4505, lw_, lill, ltag);
    check("R8", lw_ == 32'h0010_0513, lw_, 32'h0010_0513);
    @(negedge clk);
    in_valid = 1'b0;
    in_half  = 16'hffff;
    check_word(32'h4505, lw_, lill, ltag);
    @(negedge clk);
    check("R3", out_valid == 1'b0, {31'd0, out_valid}, 32'd0);
    check("R3", out_word == lw_, out_word, lw_);
    check("R3", out_illegal == 1'b0, {31'd0, out_illegal}, 32'd0);
    @(negedge clk);
    check("R3", out_word == lw_, out_word, lw_);

    in_valid = 1'b1;
    in_half  = 16'h4505;
    rst = 1'b1;
    @(negedge clk);
    check("R3", out_valid == 1'b0, {31'd0, out_valid}, 32'd0);
    check("R3", out_word == 32'd0, out_word, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule